// File: doc/BRIEF.md
# Shared-Line Interrupt Trigger Conditioner

This block sits in front of a cascaded pair of 8-input interrupt controllers and turns a stream of line events into set and clear strobes for their request latches. Each of the 16 lines may be shared by several sources. The block therefore keeps a small signed count per line. An assert event raises the count, a deassert event lowers it, and a pulse event does one and then the other over two cycles. A per-line trigger-mode bit selects edge or level behaviour. An edge-mode request is latched on the 0-to-1 step of the count. A level-mode request follows the count being positive.

Lines 0 to 7 belong to the first controller (the master) and lines 8 to 15 to the second (the slave), at bit position `line & 7`. The two 8-bit trigger-mode registers are written and read through a small register port. Some line positions are hard-wired to edge mode. A controller that reports itself uninitialized has every event on its lines discarded.

Top module: `irq_line_conditioner`

## Requirements
- R1: After reset every count is zero, both mode registers read 0x00, `cnt_err` is 0, `ev_ready` is 1, and no strobe is active.
- R2: An event that takes a line's count from 0 to 1 raises that line's bit of `req_set` for one cycle, in either mode.
- R3: In level mode (mode bit 1), any event that leaves the count positive raises the line's `req_set` bit, including 1 to 2 and 2 to 1.
- R4: A step of the count from 1 to 0 raises the line's `req_clr` bit only in level mode. In edge mode (mode bit 0) it produces no strobe.
- R5: Every other count change produces no strobe. This covers 1 to 2 and 2 to 1 in edge mode, and any step out of a negative count that does not reach 1.
- R6: An event that leaves a count negative sets `cnt_err`. The flag stays set until a cycle with `reg_rd` high clears it.
- R7: A write to the master mode register (`reg_sel`=0) stores the data ANDed with 0xF8. A write to the slave register (`reg_sel`=1) stores it ANDed with 0xDE. Lines 0, 1, 2, 8 and 13 therefore stay edge-triggered. `reg_rdata` shows the register chosen by `reg_sel`.
- R8: Line n drives bit n of `req_set`/`req_clr`, and its mode comes from bit n&7 of register n>>3. An event on a line whose controller has `ctl_ready[n>>3]`=0 is dropped and leaves the count unchanged.
- R9: A pulse event (`ev_kind`=2) acts as an assert in the cycle it is taken and as a deassert in the next cycle. During that second cycle `ev_ready` is 0.
- R10: Counts are 4-bit signed. They saturate at +7 and at -8 instead of wrapping.
- R11: Event kind 3 is ignored: no strobe, no count change. Kind 0 is assert and kind 1 is deassert.
- R12: Strobes appear in the cycle after the event is taken and last one cycle. At most one strobe bit is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_ready | input | 2 | Controller initialized flags (bit 0 master, bit 1 slave) |
| ev_valid | input | 1 | Event present |
| ev_line | input | 4 | Line number of the event |
| ev_kind | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 ignored |
| ev_ready | output | 1 | Event accepted this cycle when high |
| reg_sel | input | 1 | Mode register select (0 master, 1 slave) |
| reg_wr | input | 1 | Write strobe for the selected mode register |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; clears the error flag |
| reg_rdata | output | 8 | Selected mode register contents |
| cnt_err | output | 1 | Sticky negative-count flag |
| req_set | output | 16 | Per-line request set strobes |
| req_clr | output | 16 | Per-line request clear strobes |

## Verification
A count that is off by one shows up at the ports only when the line next crosses between 0 and 1: a missing or extra `req_set`, or a wrong `req_clr` in level mode. The bench therefore follows each disturbing event with an assert or deassert that makes the hidden count visible one cycle later. A wrong mode bit is visible at once through `reg_rdata`, and also on the next level-mode event as a set strobe that should not appear. Saturation faults stay hidden until the count has been walked back to zero, so those tests run full sweeps of the count range.

// File: rtl/irq_line_conditioner.sv
module irq_line_conditioner #(
  parameter int CNT_W = 4,
  parameter logic [7:0] M_EDGE_ONLY = 8'h07,
  parameter logic [7:0] S_EDGE_ONLY = 8'h21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ctl_ready,
  input  logic        ev_valid,
  input  logic [3:0]  ev_line,
  input  logic [1:0]  ev_kind,
  output logic        ev_ready,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  output logic        cnt_err,
  output logic [15:0] req_set,
  output logic [15:0] req_clr
);
  localparam int NL = 16;
  localparam logic signed [CNT_W-1:0] C_ONE = 1;
  localparam logic signed [CNT_W-1:0] C_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] C_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [CNT_W-1:0] cnt [NL];
  logic [7:0] elc_m, elc_s;
  logic       pend;
  logic [3:0] pend_line;

  logic        take, act_go, act_up, lvl;
  logic [3:0]  act_line;
  logic [15:0] lvl_vec;
  logic signed [CNT_W-1:0] c_old, c_new;
  logic        do_set, do_clr;

  assign ev_ready  = !pend;
  assign take      = ev_valid && ev_ready && ev_kind != 2'd3 && ctl_ready[ev_line[3]];
  assign act_go    = pend || take;
  assign act_line  = pend ? pend_line : ev_line;
  assign act_up    = !pend && (ev_kind == 2'd0 || ev_kind == 2'd2);
  assign lvl_vec   = {elc_s, elc_m};
  assign lvl       = lvl_vec[act_line];
  assign c_old     = cnt[act_line];
  assign reg_rdata = reg_sel ? elc_s : elc_m;

  always_comb begin
    if (act_up) c_new = (c_old == C_MAX) ? c_old : c_old + C_ONE;
    else        c_new = (c_old == C_MIN) ? c_old : c_old - C_ONE;
  end

  assign do_set = act_go && ((c_old == 0 && c_new == C_ONE) || (c_new > 0 && lvl));
  assign do_clr = act_go && !do_set && c_old == C_ONE && c_new == 0 && lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) cnt[i] <= '0;
      pend      <= 1'b0;
      pend_line <= '0;
      req_set   <= '0;
      req_clr   <= '0;
      cnt_err   <= 1'b0;
    end else begin
      pend      <= take && ev_kind == 2'd2;
      pend_line <= ev_line;
      if (act_go) cnt[act_line] <= c_new;
      req_set <= do_set ? (16'd1 << act_line) : 16'd0;
      req_clr <= do_clr ? (16'd1 << act_line) : 16'd0;
      if (act_go && c_new < 0) cnt_err <= 1'b1;
      else if (reg_rd)         cnt_err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elc_m <= '0;
      elc_s <= '0;
    end else if (reg_wr) begin
      if (reg_sel) elc_s <= reg_wdata & ~S_EDGE_ONLY;
      else         elc_m <= reg_wdata & ~M_EDGE_ONLY;
    end
  end
endmodule

// File: rtl/irq_line_conditioner_chk.sv
module irq_line_conditioner_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  ctl_ready,
  input logic        ev_valid,
  input logic [3:0]  ev_line,
  input logic [1:0]  ev_kind,
  input logic        ev_ready,
  input logic        reg_rd,
  input logic        cnt_err,
  input logic [15:0] req_set,
  input logic [15:0] req_clr,
  input logic [7:0]  elc_m,
  input logic [7:0]  elc_s
);
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_set, req_clr}) <= 1);

  assert_idle_no_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready && !ev_valid) |=> (req_set == 16'd0 && req_clr == 16'd0));

  assert_forced_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (elc_m & 8'h07) == 8'h00 && (elc_s & 8'h21) == 8'h00);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_err && !reg_rd) |=> cnt_err);

  assert_pulse_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_kind == 2'd2 && ctl_ready[ev_line[3]]) |=> !ev_ready);

  assert_drop_unready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !ctl_ready[ev_line[3]]) |=> (req_set == 16'd0 && req_clr == 16'd0));

  assert_reserved_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_kind == 2'd3) |=> (req_set == 16'd0 && req_clr == 16'd0));
endmodule

bind irq_line_conditioner irq_line_conditioner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready), .ev_valid(ev_valid),
  .ev_line(ev_line), .ev_kind(ev_kind), .ev_ready(ev_ready), .reg_rd(reg_rd),
  .cnt_err(cnt_err), .req_set(req_set), .req_clr(req_clr),
  .elc_m(elc_m), .elc_s(elc_s)
);

// File: tb/irq_line_conditioner_test.sv
module irq_line_conditioner_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ctl_ready = 2'b11;
  logic        ev_valid = 0;
  logic [3:0]  ev_line = 0;
  logic [1:0]  ev_kind = 0;
  logic        ev_ready;
  logic        reg_sel = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        cnt_err;
  logic [15:0] req_set, req_clr;

  int total = 0, bad = 0;
  logic [15:0] s, c, s2, c2;

  always #10 clk = ~clk;

  irq_line_conditioner uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input [3:0] l, input [1:0] k, output logic [15:0] so, output logic [15:0] co);
    @(negedge clk); ev_valid = 1; ev_line = l; ev_kind = k;
    @(negedge clk); ev_valid = 0; so = req_set; co = req_clr;
  endtask

  task automatic expect_ev(input [3:0] l, input [1:0] k, input [15:0] es, input [15:0] ec, input string req);
    ev(l, k, s, c);
    chk(s == es, req, s, es);
    chk(c == ec, req, c, ec);
  endtask

  task automatic wr(input bit sel, input [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_clear();
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic t_reset();
    chk(req_set == 0 && req_clr == 0, "R1 strobes", {req_set, req_clr}, 0);
    chk(cnt_err == 0, "R1 err", cnt_err, 0);
    chk(ev_ready == 1, "R1 ready", ev_ready, 1);
    reg_sel = 0; #1 chk(reg_rdata == 0, "R1 master reg", reg_rdata, 0);
    reg_sel = 1; #1 chk(reg_rdata == 0, "R1 slave reg", reg_rdata, 0);
  endtask

  task automatic t_masks();
    wr(0, 8'hFF); chk(reg_rdata == 8'hF8, "R7 master mask", reg_rdata, 8'hF8);
    wr(1, 8'hFF); chk(reg_rdata == 8'hDE, "R7 slave mask", reg_rdata, 8'hDE);
    wr(0, 8'h0F); chk(reg_rdata == 8'h08, "R7 master write", reg_rdata, 8'h08);
    wr(1, 8'h23); chk(reg_rdata == 8'h02, "R7 slave write", reg_rdata, 8'h02);
  endtask

  task automatic t_edge();
    expect_ev(5, 0, 16'h0020, 0, "R2 edge rise");
    @(negedge clk); chk(req_set == 0, "R12 one cycle", req_set, 0);
    expect_ev(5, 0, 0, 0, "R5 edge 1to2");
    expect_ev(5, 1, 0, 0, "R5 edge 2to1");
    expect_ev(5, 1, 0, 0, "R4 edge fall no clear");
    expect_ev(13, 0, 16'h2000, 0, "R8 line13 rise");
    expect_ev(13, 0, 0, 0, "R7 line13 stays edge");
    expect_ev(13, 1, 0, 0, "R7 line13 down");
    expect_ev(13, 1, 0, 0, "R7 line13 fall");
  endtask

  task automatic t_level();
    expect_ev(3, 0, 16'h0008, 0, "R2 level rise");
    expect_ev(3, 0, 16'h0008, 0, "R3 level 1to2");
    expect_ev(3, 1, 16'h0008, 0, "R3 level 2to1");
    expect_ev(3, 1, 0, 16'h0008, "R4 level fall");
    expect_ev(9, 0, 16'h0200, 0, "R8 slave level rise");
    expect_ev(9, 1, 0, 16'h0200, "R8 slave level fall");
  endtask

  task automatic t_negative();
    expect_ev(6, 1, 0, 0, "R5 to negative");
    chk(cnt_err == 1, "R6 err set", cnt_err, 1);
    @(negedge clk); chk(cnt_err == 1, "R6 err sticky", cnt_err, 1);
    rd_clear(); chk(cnt_err == 0, "R6 err cleared", cnt_err, 0);
    expect_ev(6, 0, 0, 0, "R5 neg to zero");
    expect_ev(6, 0, 16'h0040, 0, "R2 rise after neg");
    expect_ev(6, 1, 0, 0, "R4 edge back to zero");
  endtask

  task automatic t_unready();
    ctl_ready = 2'b01;
    expect_ev(10, 0, 0, 0, "R8 dropped on unready slave");
    chk(cnt_err == 0, "R8 no effect", cnt_err, 0);
    ctl_ready = 2'b11;
    expect_ev(10, 0, 16'h0400, 0, "R8 count unchanged after drop");
    expect_ev(10, 1, 0, 0, "R8 cleanup");
  endtask

  task automatic t_pulse();
    ev(4, 2, s, c);
    chk(s == 16'h0010, "R9 pulse assert half", s, 16'h0010);
    chk(ev_ready == 0, "R9 stall", ev_ready, 0);
    @(negedge clk); s2 = req_set; c2 = req_clr;
    chk(s2 == 0 && c2 == 0, "R9 edge pulse deassert", {s2, c2}, 0);
    chk(ev_ready == 1, "R9 ready again", ev_ready, 1);
    ev(3, 2, s, c);
    chk(s == 16'h0008, "R9 level pulse set", s, 16'h0008);
    @(negedge clk); c2 = req_clr;
    chk(c2 == 16'h0008, "R9 level pulse clear", c2, 16'h0008);
    expect_ev(4, 0, 16'h0010, 0, "R9 count back at zero");
    expect_ev(4, 1, 0, 0, "R9 cleanup");
  endtask

  task automatic t_reserved();
    expect_ev(7, 3, 0, 0, "R11 kind3 no strobe");
    expect_ev(7, 0, 16'h0080, 0, "R11 kind3 no count change");
    expect_ev(7, 1, 0, 0, "R11 cleanup");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 8; i++) ev(11, 0, s, c);
    for (int i = 0; i < 7; i++) ev(11, 1, s, c);
    chk(cnt_err == 0, "R10 no wrap to negative", cnt_err, 0);
    expect_ev(11, 0, 16'h0800, 0, "R10 top saturation");
    expect_ev(11, 1, 0, 0, "R10 cleanup top");
    for (int i = 0; i < 9; i++) ev(12, 1, s, c);
    chk(cnt_err == 1, "R6 err deep negative", cnt_err, 1);
    for (int i = 0; i < 8; i++) ev(12, 0, s, c);
    chk(s == 0, "R10 still zero after climb", s, 0);
    expect_ev(12, 0, 16'h1000, 0, "R10 bottom saturation");
    rd_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masks();
    t_edge();
    t_level();
    t_negative();
    t_unready();
    t_pulse();
    t_reserved();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule